// File: doc/BRIEF.md
# Configurable Interrupt Source Conditioner

This block sits between a set of raw interrupt request lines and an interrupt prioritizer. Each channel has its own small conditioner. A 2-bit sensitivity setting per channel decides how the raw line becomes a pending request. The line can act as a level that is active low or active high. It can also act as a falling or rising edge that is caught and held.

The prioritizer reads the pending vector. When it acknowledges a channel, it sends a one-cycle clear pulse on that channel. In the edge modes the clear drops the held request. In the level modes the request simply follows the line, so the clear does nothing. A raw status vector repeats the incoming lines so that the raw state and the pending state of every channel can be seen side by side. All inputs are taken to be synchronous to the block clock already.

Top module: `irq_cond_array`

## Requirements
- R1: After a synchronous active-low reset, each channel's stored mode is high-level (01) and every held edge flag is clear. With all lines low and the mode set to 01, `pend_out` reads all zeros.
- R2: Mode 01 (high level): `pend_out[i]` equals `raw_in[i]` in the same cycle and is never latched.
- R3: Mode 00 (low level): `pend_out[i]` equals the inverse of `raw_in[i]` in the same cycle.
- R4: Mode 11 (rising edge): `raw_in[i]` is 1 at a clock edge after it was 0 at the previous edge, with no mode change. This sets a held flag, and `pend_out[i]` is 1 from that edge on. The flag stays set until it is cleared.
- R5: Mode 10 (falling edge): a 1-to-0 change between consecutive clock edges sets the held flag in the same way.
- R6: In an edge mode, `ack_clr[i]` high at a clock edge with no new edge drops the flag, so `pend_out[i]` is 0 after that edge.
- R7: If a new edge and `ack_clr[i]` arrive at the same clock edge, the flag stays set.
- R8: Whenever `mode_cfg` for a channel differs from its stored mode, that edge clears the held flag and no edge is detected. This gives no false edge from a mode switch.
- R9: In the level modes `ack_clr[i]` has no effect on `pend_out[i]`.
- R10: `raw_stat[i]` always equals `raw_in[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | NCH | Raw interrupt lines, synchronous to clk |
| mode_cfg | input | 2*NCH | Per-channel sensitivity; channel i uses bits [2i+1:2i]: 00 low, 01 high, 10 fall, 11 rise |
| ack_clr | input | NCH | One-cycle acknowledge clear per channel from the prioritizer |
| pend_out | output | NCH | Conditioned pending request per channel |
| raw_stat | output | NCH | Raw line status per channel |

## Verification
The bench targets four cases: an edge that coincides with an acknowledge, a mode switch while the line is already high or falling, the acknowledge in a level mode, and a flag that must survive many idle cycles. A design that let the clear win over the edge would lose that request. A design that kept stale history across a mode switch would raise a request with no real edge. A design that latched level requests, or cleared them on acknowledge, would disagree with the line on the same cycle. Random traffic on all channels, with rare mode changes, is compared every cycle against a bench model built from the requirements.

// File: rtl/irq_cond_pkg.sv
// Shared definitions for the interrupt source conditioner.
package irq_cond_pkg;
    // Sensitivity encoding; the low bit selects polarity or direction, the high bit selects edge.
    typedef enum logic [1:0] {
        SENS_LOW  = 2'b00,
        SENS_HIGH = 2'b01,
        SENS_FALL = 2'b10,
        SENS_RISE = 2'b11
    } sens_mode_e;

    localparam sens_mode_e SENS_DEFAULT = SENS_HIGH;
endpackage

// File: rtl/irq_cond_edge.sv
// Edge detector for one channel.
// Keeps the previous line value and the previously applied mode. Reports a
// detected edge in the direction chosen by the mode. Reports a mode change,
// during which detection is suppressed.
// Assumes raw is synchronous to clk.
module irq_cond_edge
    import irq_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  sens_mode_e mode,
    output logic       edge_hit,
    output logic       mode_chg
);
    logic       prev_q;
    sens_mode_e mode_q;

    // Track the line and the mode as seen at the last clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            mode_q <= SENS_DEFAULT;
        end else begin
            prev_q <= raw;
            mode_q <= mode;
        end
    end

    // Decide whether this cycle carries a qualifying edge.
    always_comb begin
        mode_chg = (mode != mode_q);
        unique case (mode)
            SENS_RISE: edge_hit = raw & ~prev_q;
            SENS_FALL: edge_hit = ~raw & prev_q;
            default:   edge_hit = 1'b0;
        endcase
        if (mode_chg) edge_hit = 1'b0;
    end

    AST_NO_EDGE_IN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENS_LOW || mode == SENS_HIGH) |-> !edge_hit); // R2
endmodule

// File: rtl/irq_cond_chan.sv
// One conditioned channel.
// In level modes the request follows the line with the chosen polarity. In
// edge modes a held flag is set by a detected edge and dropped by the
// acknowledge clear. A new edge wins over a simultaneous clear, and a mode
// change empties the flag.
module irq_cond_chan
    import irq_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw,
    input  sens_mode_e mode,
    input  logic       clr,
    output logic       pending
);
    logic edge_hit;
    logic mode_chg;
    logic flag_q;
    logic is_edge_mode;

    irq_cond_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (raw),
        .mode     (mode),
        .edge_hit (edge_hit),
        .mode_chg (mode_chg)
    );

    assign is_edge_mode = (mode == SENS_FALL) || (mode == SENS_RISE);

    // Held flag: the edge has priority over the clear; a mode change or level mode empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (mode_chg || !is_edge_mode) begin
            flag_q <= 1'b0;
        end else if (edge_hit) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    // Select the request seen by the prioritizer.
    always_comb begin
        unique case (mode)
            SENS_LOW:  pending = ~raw;
            SENS_HIGH: pending = raw;
            default:   pending = flag_q;
        endcase
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> flag_q); // R7
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge_mode && !mode_chg && flag_q && !clr) |=> flag_q); // R4
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge_mode && !mode_chg && clr && !edge_hit) |=> !flag_q); // R6
    AST_MODE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !flag_q); // R8
endmodule

// File: rtl/irq_cond_array.sv
// Array of per-channel interrupt source conditioners.
// Each channel turns its raw line into a pending request according to its
// 2-bit sensitivity setting and accepts an acknowledge clear. The raw lines
// are mirrored on a status output. Inputs are assumed synchronous to clk.
module irq_cond_array
    import irq_cond_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   raw_in,
    input  logic [2*NCH-1:0] mode_cfg,
    input  logic [NCH-1:0]   ack_clr,
    output logic [NCH-1:0]   pend_out,
    output logic [NCH-1:0]   raw_stat
);
    localparam int MODE_W = 2;

    // Raw status is a plain view of the incoming lines.
    assign raw_stat = raw_in;

    // One conditioner per channel.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        irq_cond_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (raw_in[i]),
            .mode    (sens_mode_e'(mode_cfg[MODE_W*i +: MODE_W])),
            .clr     (ack_clr[i]),
            .pending (pend_out[i])
        );
    end

    AST_STAT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        raw_stat == raw_in); // R10
endmodule

// File: tb/irq_cond_array_test.sv
module irq_cond_array_test;
    localparam int NCH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   raw_in = '0;
    logic [2*NCH-1:0] mode_cfg = {NCH{2'b01}};
    logic [NCH-1:0]   ack_clr = '0;
    logic [NCH-1:0]   pend_out;
    logic [NCH-1:0]   raw_stat;

    int checks = 0;
    int fails  = 0;

    // bench model state
    logic       m_prev [NCH];
    logic [1:0] m_mode [NCH];
    logic       m_flag [NCH];

    always #4 clk = ~clk;

    irq_cond_array #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .mode_cfg(mode_cfg),
        .ack_clr(ack_clr), .pend_out(pend_out), .raw_stat(raw_stat)
    );

    function automatic logic exp_pend(int i);
        logic [1:0] md = mode_cfg[2*i +: 2];
        if (md == 2'b00) return ~raw_in[i];
        if (md == 2'b01) return raw_in[i];
        return m_flag[i];
    endfunction

    function automatic string tag_of(logic [1:0] md);
        case (md)
            2'b00: return "R3";
            2'b01: return "R2";
            2'b10: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_prev[i] = 1'b0; m_mode[i] = 2'b01; m_flag[i] = 1'b0;
        end
    endtask

    // one cycle: apply inputs, compare every channel, then advance the model at the edge
    task automatic drive(logic [NCH-1:0] r, logic [2*NCH-1:0] m, logic [NCH-1:0] c);
        @(negedge clk);
        raw_in = r; mode_cfg = m; ack_clr = c;
        #1;
        for (int i = 0; i < NCH; i++) begin
            chk(pend_out[i], exp_pend(i), tag_of(mode_cfg[2*i +: 2]));
            chk(raw_stat[i], raw_in[i], "R10");
        end
        @(posedge clk);
        for (int i = 0; i < NCH; i++) begin
            logic [1:0] md = mode_cfg[2*i +: 2];
            logic chg = (md != m_mode[i]);
            logic hit = !chg && ((md == 2'b11 && raw_in[i] && !m_prev[i]) ||
                                 (md == 2'b10 && !raw_in[i] && m_prev[i]));
            if (chg || md[1] == 1'b0) m_flag[i] = 1'b0;
            else if (hit)             m_flag[i] = 1'b1;
            else if (ack_clr[i])      m_flag[i] = 1'b0;
            m_mode[i] = md;
            m_prev[i] = raw_in[i];
        end
    endtask

    function automatic logic [2*NCH-1:0] ch0_mode(logic [1:0] md);
        return {{(NCH-1){2'b01}}, md};
    endfunction

    // watchdog
    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [2*NCH-1:0] m;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(pend_out == '0, 1'b1, "R1");
        chk(raw_stat == '0, 1'b1, "R1");

        // R2 / R10: high level follows the line
        drive(8'h01, ch0_mode(2'b01), '0);
        #2; chk(pend_out[0], 1'b1, "R2");
        chk(raw_stat[0], 1'b1, "R10");
        // R3: low level inverts
        drive(8'h00, ch0_mode(2'b00), '0);
        #2; chk(pend_out[0], 1'b1, "R3");
        // R9: clear ignored in level mode
        drive(8'h00, ch0_mode(2'b00), 8'h01);
        #2; chk(pend_out[0], 1'b1, "R9");
        // R4: rising edge sets and holds
        drive(8'h00, ch0_mode(2'b11), '0);
        drive(8'h00, ch0_mode(2'b11), '0);
        drive(8'h01, ch0_mode(2'b11), '0);
        #2; chk(pend_out[0], 1'b1, "R4");
        drive(8'h00, ch0_mode(2'b11), '0);
        repeat (5) drive(8'h00, ch0_mode(2'b11), '0);
        #2; chk(pend_out[0], 1'b1, "R4");
        // R6: clear drops it
        drive(8'h00, ch0_mode(2'b11), 8'h01);
        #2; chk(pend_out[0], 1'b0, "R6");
        // R7: edge with clear keeps it
        drive(8'h01, ch0_mode(2'b11), 8'h01);
        #2; chk(pend_out[0], 1'b1, "R7");
        // R8: mode switch empties the flag, and a falling line at the switch is no edge
        drive(8'h00, ch0_mode(2'b10), '0);
        #2; chk(pend_out[0], 1'b0, "R8");
        // R5: falling edge sets
        drive(8'h01, ch0_mode(2'b10), '0);
        drive(8'h00, ch0_mode(2'b10), '0);
        #2; chk(pend_out[0], 1'b1, "R5");
        // R8: switch to rising with line held high clears and raises nothing
        drive(8'h01, ch0_mode(2'b11), '0);
        drive(8'h01, ch0_mode(2'b11), '0);
        #2; chk(pend_out[0], 1'b0, "R8");
        // R9: back to high level, clear has no effect
        drive(8'h01, ch0_mode(2'b01), 8'h01);
        #2; chk(pend_out[0], 1'b1, "R9");

        // random traffic, rare mode changes, every channel checked each cycle
        m = mode_cfg;
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NCH; i++)
                if ($urandom_range(15) == 0) m[2*i +: 2] = 2'($urandom_range(3));
            drive(NCH'($urandom), m, NCH'($urandom) & NCH'($urandom));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule